// File: doc/BRIEF.md
# Interleaved Converter Mismatch Corrector

This block sits on the merged output stream of a four-way time-interleaved converter and removes the per-path errors that otherwise show up as interleaving spurs. Every accepted sample is assigned to a sub-converter by a round-robin phase counter. That phase picks one coefficient set. The sample first gets that set's DC trim added. The result is then scaled by that set's gain. Finally a three-tap fractional-delay correction is applied. The correction adds a weighted sum of the newest and two preceding corrected samples of the merged stream to the newest one, which moves its effective sampling instant.

Software writes coefficients into a shadow bank through a small write port and then raises a commit strobe. A two-state controller holds the request. State IDLE means no commit is outstanding. State ARMED means a commit is waiting. IDLE moves to ARMED on a commit strobe. ARMED moves back to IDLE at the rotation boundary, unless a fresh strobe arrives in that same cycle, in which case it stays in ARMED. The rotation boundary is the cycle that accepts a channel-3 sample. At that boundary the whole shadow bank is copied into the active bank. As a result, no rotation of four samples ever mixes old and new coefficients.

Top module: `tic_skew_corrector`

## Requirements
- R1: The channel of an accepted sample (`in_valid`=1) is the phase counter value. The counter runs 0,1,2,3,0 and advances only on accepted samples. A `sync` pulse makes the next accepted sample channel 0; a sample accepted in the same cycle as `sync` keeps the current phase.
- R2: The corrected sample is c = sat(floor((x + off[ch]) * gain[ch] / 32768)). Here off is the signed 12-bit trim, taken from bits 11:0 of the written word.
- R3: Gain is unsigned Q1.15, so 0x8000 means 1.0 and 0xFFFF is just under 2.0.
- R4: The output is y = sat(c[n] + floor((t0*c[n] + t1*c[n-1] + t2*c[n-2]) / 32768)). The taps are signed Q1.15 values of the channel of sample n. c[n-1] and c[n-2] are the previous accepted samples of any channel. Reset clears this history to 0.
- R5: Both sat() steps clamp to the range -2048..2047; the result never wraps.
- R6: `out_valid` equals `in_valid` delayed by exactly 3 clock cycles. `out_data` carries the result for that sample.
- R7: A write goes to the shadow bank entry of `cfg_ch`. The field is chosen by `cfg_sel`: 0 selects the trim, 1 the gain, 2 t0, 3 t1 and 4 t2. Codes 5 to 7 are ignored. No write changes the output until it is committed.
- R8: After `cfg_commit`, the active bank takes the complete shadow bank at the edge that accepts a channel-3 sample. That sample still uses the old set, and the following sample uses the new set. A shadow write in the copy cycle is not part of that copy.
- R9: After reset, every channel holds the identity set (trim 0, gain 0x8000, taps 0), so the output equals the input. `out_valid` and `out_data` are 0 right after reset.
- R10: The controller is in ARMED exactly while a commit is outstanding. It enters ARMED only after a commit strobe. It leaves ARMED at a boundary that has no new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Restart the rotation at channel 0 |
| in_valid | input | 1 | Sample on in_data is accepted |
| in_data | input | 12 | Signed merged-stream sample |
| cfg_wr | input | 1 | Shadow bank write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 3 | Field select (0 trim, 1 gain, 2..4 taps) |
| cfg_data | input | 16 | Write value |
| cfg_commit | input | 1 | Request shadow-to-active copy at next boundary |
| out_valid | output | 1 | out_data holds a corrected sample |
| out_data | output | 12 | Signed corrected sample |

## Verification
First, an identity stream with the reset coefficients separates a pass-through datapath from one that distorts the samples. Next come distinct per-channel trims and gains, which expose a wrong channel selection or a wrong stage order. Extreme trim and gain values force both clamps. Nonzero taps separate correct merged-stream history from per-channel history. Commits placed mid-rotation, shadow writes that are never committed, and ignored field codes test the boundary rule. Gaps in the valid stream and sync pulses placed mid-rotation test the phase counter. A seeded random section then mixes all of these patterns.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int SW       = 12;              // sample width
    localparam int CW       = 16;              // coefficient width
    localparam int FRAC     = 15;              // fractional bits of gain and taps
    localparam int NCH      = 4;               // interleaved channels
    localparam int NTAP     = 3;               // timing FIR taps
    localparam int CHW      = $clog2(NCH);
    localparam int SELW     = 3;
    localparam int SMAX     = (2 ** (SW - 1)) - 1;
    localparam int SMIN     = -(2 ** (SW - 1));
    localparam int SEL_OFF  = 0;
    localparam int SEL_GAIN = 1;
    localparam int SEL_TAP0 = 2;

    typedef logic signed [SW-1:0] samp_t;

    typedef struct packed {
        logic [NTAP-1:0][CW-1:0] tap;
        logic [CW-1:0]           gain;
        logic [SW-1:0]           off;
    } coef_t;

    localparam coef_t COEF_IDENT = '{tap: '0, gain: CW'(1 << FRAC), off: '0};

    function automatic samp_t sat_s(input logic signed [31:0] v);
        if (v > SMAX)      return SW'(SMAX);
        else if (v < SMIN) return SW'(SMIN);
        else               return v[SW-1:0];
    endfunction
endpackage

// File: rtl/tic_coef_bank.sv
module tic_coef_bank
    import tic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [CHW-1:0]        cfg_ch,
    input  logic [SELW-1:0]       cfg_sel,
    input  logic [CW-1:0]         cfg_data,
    input  logic                  cfg_commit,
    input  logic                  boundary,
    output coef_t [NCH-1:0]       active_o,
    output logic                  armed_o
);
    typedef enum logic {CB_IDLE, CB_ARMED} cb_state_e;

    cb_state_e       state_q, state_d;
    logic            copy_en;
    coef_t [NCH-1:0] shadow_q, active_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CB_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CB_IDLE:  if (cfg_commit) state_d = CB_ARMED;
            CB_ARMED: if (boundary && !cfg_commit) state_d = CB_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        copy_en = 1'b0;
        armed_o = 1'b0;
        unique case (state_q)
            CB_IDLE:  ;
            CB_ARMED: begin
                copy_en = boundary;
                armed_o = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                shadow_q[c] <= COEF_IDENT;
                active_q[c] <= COEF_IDENT;
            end
        end else begin
            if (copy_en) active_q <= shadow_q;
            if (cfg_wr) begin
                for (int c = 0; c < NCH; c++) begin
                    if (cfg_ch == CHW'(c)) begin
                        if (cfg_sel == SELW'(SEL_OFF))  shadow_q[c].off  <= cfg_data[SW-1:0];
                        if (cfg_sel == SELW'(SEL_GAIN)) shadow_q[c].gain <= cfg_data;
                        for (int k = 0; k < NTAP; k++) begin
                            if (cfg_sel == SELW'(SEL_TAP0 + k)) shadow_q[c].tap[k] <= cfg_data;
                        end
                    end
                end
            end
        end
    end

    assign active_o = active_q;
endmodule

// File: rtl/tic_datapath.sv
module tic_datapath
    import tic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  samp_t in_data,
    input  coef_t coef,
    output logic  out_valid,
    output samp_t out_data
);
    // stage 1: trim
    logic                    v1;
    logic signed [SW:0]      a1;
    logic [CW-1:0]           g1;
    logic [NTAP-1:0][CW-1:0] t1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            a1 <= '0;
            g1 <= '0;
            t1 <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                a1 <= (SW+1)'(in_data) + (SW+1)'($signed(coef.off));
                g1 <= coef.gain;
                t1 <= coef.tap;
            end
        end
    end

    // stage 2: gain, then push into merged-stream history
    logic signed [31:0]      prod, gsh;
    samp_t                   c2;
    logic                    v2;
    samp_t                   hist [NTAP];
    logic [NTAP-1:0][CW-1:0] t2;

    always_comb begin
        prod = 32'(a1) * $signed({{(32-CW){1'b0}}, g1});
        gsh  = prod >>> FRAC;
        c2   = sat_s(gsh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v2 <= 1'b0;
            t2 <= '0;
            for (int k = 0; k < NTAP; k++) hist[k] <= '0;
        end else begin
            v2 <= v1;
            if (v1) begin
                hist[0] <= c2;
                for (int k = 1; k < NTAP; k++) hist[k] <= hist[k-1];
                t2 <= t1;
            end
        end
    end

    // stage 3: fractional-delay correction
    logic signed [31:0] term [NTAP];
    logic signed [31:0] acc, fsh;
    samp_t              y3;

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        assign term[k] = 32'(hist[k]) * 32'($signed(t2[k]));
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAP; k++) acc = acc + term[k];
        fsh = acc >>> FRAC;
        y3  = sat_s(32'(hist[0]) + fsh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= v2;
            if (v2) out_data <= y3;
        end
    end
endmodule

// File: rtl/tic_skew_corrector.sv
module tic_skew_corrector
    import tic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_data,
    input  logic                 cfg_wr,
    input  logic [CHW-1:0]       cfg_ch,
    input  logic [SELW-1:0]      cfg_sel,
    input  logic [CW-1:0]        cfg_data,
    input  logic                 cfg_commit,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_data
);
    localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

    logic [CHW-1:0]  phase_q;
    logic            boundary;
    logic            commit_armed;
    coef_t [NCH-1:0] active_bank;
    coef_t           sel_coef;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        phase_q <= '0;
        else if (sync)     phase_q <= '0;
        else if (in_valid) phase_q <= phase_q + 1'b1;
    end

    assign boundary = in_valid && (phase_q == LAST_CH);
    assign sel_coef = active_bank[phase_q];

    tic_coef_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_ch     (cfg_ch),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .cfg_commit (cfg_commit),
        .boundary   (boundary),
        .active_o   (active_bank),
        .armed_o    (commit_armed)
    );

    tic_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .coef      (sel_coef),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/tic_skew_corrector_chk.sv
module tic_skew_corrector_chk
    import tic_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            sync,
    input logic            in_valid,
    input logic            cfg_commit,
    input logic            out_valid,
    input logic [CHW-1:0]  phase,
    input coef_t [NCH-1:0] active,
    input logic            armed
);
    logic [1:0]     since_rst;
    logic [CHW-1:0] phase_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign phase_nx = phase + 1'b1;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !sync) |=> (phase == $past(phase_nx))); // R1
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!in_valid && !sync) |=> $stable(phase)); // R1
    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n) sync |=> (phase == '0)); // R1
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n) (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R6
    AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !(in_valid && phase == CHW'(NCH - 1)) |=> $stable(active)); // R8
    AST_ARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(armed) |-> $past(cfg_commit)); // R10
    AST_ARM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (armed && !cfg_commit && in_valid && phase == CHW'(NCH - 1)) |=> !armed); // R10
endmodule

bind tic_skew_corrector tic_skew_corrector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync       (sync),
    .in_valid   (in_valid),
    .cfg_commit (cfg_commit),
    .out_valid  (out_valid),
    .phase      (phase_q),
    .active     (active_bank),
    .armed      (commit_armed)
);

// File: tb/tic_skew_corrector_bench.sv
module tic_skew_corrector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic        cfg_commit = 1'b0;
    logic        out_valid;
    logic [11:0] out_data;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    string cur_req = "R9";

    // reference model state
    longint m_sh [4][5];
    longint m_act[4][5];
    longint m_hist[3];
    int     m_phase = 0;
    bit     m_pend = 1'b0;
    bit     ev[3];
    logic [11:0] ed[3];

    always #5 clk = ~clk;

    tic_skew_corrector u_tic_skew_corrector (
        .clk(clk), .rst_n(rst_n), .sync(sync), .in_valid(in_valid), .in_data(in_data),
        .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .cfg_commit(cfg_commit), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint sxw(longint v, int w);
        longint m = v & ((longint'(1) << w) - 1);
        if (m >= (longint'(1) << (w - 1))) m = m - (longint'(1) << w);
        return m;
    endfunction

    function automatic longint sat12(longint v);
        if (v > 2047)  return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic longint trim_gain(longint x, longint off, longint gain);
        longint p = (x + off) * gain;
        return sat12(p >>> 15);
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 5; f++) begin
                m_sh[c][f]  = (f == 1) ? 64'h8000 : 0;
                m_act[c][f] = m_sh[c][f];
            end
        end
        for (int k = 0; k < 3; k++) begin
            m_hist[k] = 0;
            ev[k] = 1'b0;
            ed[k] = '0;
        end
        m_phase = 0;
        m_pend  = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    task automatic step(bit v, logic [11:0] x, bit s, bit w, int ch, int sel, logic [15:0] d, bit cm);
        longint c, acc, y;
        bit     cp;
        @(negedge clk);
        nchk++;
        if (out_valid !== ev[2]) begin
            nfail++;
            $display("FAIL R6 out_valid actual=%0b expected=%0b", out_valid, ev[2]);
        end
        if (ev[2]) begin
            nchk++;
            if (out_data !== ed[2]) begin
                nfail++;
                $display("FAIL %s out_data actual=%0d expected=%0d", cur_req,
                         $signed(out_data), $signed(ed[2]));
            end
        end
        in_valid = v; in_data = x; sync = s; cfg_wr = w; cfg_ch = 2'(ch);
        cfg_sel = 3'(sel); cfg_data = d; cfg_commit = cm;
        y = 0;
        if (v) begin
            c = trim_gain(sxw(longint'(x), 12), sxw(m_act[m_phase][0], 12), m_act[m_phase][1]);
            m_hist[2] = m_hist[1];
            m_hist[1] = m_hist[0];
            m_hist[0] = c;
            acc = 0;
            for (int k = 0; k < 3; k++) acc += sxw(m_act[m_phase][2 + k], 16) * m_hist[k];
            y = sat12(m_hist[0] + (acc >>> 15));
        end
        ev[2] = ev[1]; ev[1] = ev[0]; ev[0] = v;
        ed[2] = ed[1]; ed[1] = ed[0]; ed[0] = 12'(y);
        cp = m_pend && v && (m_phase == 3);
        if (cp) m_act = m_sh;
        if (w && sel < 5) m_sh[ch][sel] = longint'(d);
        m_pend = cm || (m_pend && !cp);
        if (s)      m_phase = 0;
        else if (v) m_phase = (m_phase + 1) % 4;
    endtask

    task automatic samp(logic [11:0] x);
        step(1'b1, x, 1'b0, 1'b0, 0, 0, 16'h0, 1'b0);
    endtask

    task automatic wr(int ch, int sel, logic [15:0] d);
        step(1'b0, 12'h0, 1'b0, 1'b1, ch, sel, d, 1'b0);
    endtask

    task automatic commit_idle();
        step(1'b0, 12'h0, 1'b0, 1'b0, 0, 0, 16'h0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        model_reset();
        repeat (4) @(negedge clk);
        // R9: reset state
        nchk++;
        if (out_valid !== 1'b0 || out_data !== 12'h0) begin
            nfail++;
            $display("FAIL R9 reset outputs actual=%0b/%0d expected=0/0", out_valid, out_data);
        end
        rst_n = 1'b1;

        // R9: identity with reset coefficients
        cur_req = "R9";
        foreach (ed[i]) ;
        samp(12'h7FF); samp(12'h800); samp(12'h001); samp(12'hFFF);
        samp(12'h123); samp(12'hA5A);

        // R7: uncommitted and ignored writes leave the output unchanged
        cur_req = "R7";
        wr(0, 0, 16'h0050); wr(1, 1, 16'h4000); wr(2, 5, 16'h1234); wr(3, 7, 16'hFFFF);
        for (int i = 0; i < 8; i++) samp(12'(i * 300));

        // R8: commit mid-rotation, switch happens at the next channel 0
        cur_req = "R8";
        samp(12'h010);
        commit_idle();
        for (int i = 0; i < 10; i++) samp(12'(100 + i));
        // shadow write in the copy cycle must not be part of that copy
        wr(0, 0, 16'h0F00);
        commit_idle();
        samp(12'h020); samp(12'h020);
        step(1'b1, 12'h020, 1'b0, 1'b1, 1, 0, 16'h0123, 1'b0);
        for (int i = 0; i < 10; i++) samp(12'h040);

        // R2 R3: distinct trims and gains per channel
        cur_req = "R2 R3";
        wr(0, 0, 16'h0010); wr(0, 1, 16'h8000);
        wr(1, 0, 16'h0FF0); wr(1, 1, 16'hC000);
        wr(2, 0, 16'h0000); wr(2, 1, 16'h4000);
        wr(3, 0, 16'h0005); wr(3, 1, 16'hFFFF);
        commit_idle();
        for (int i = 0; i < 16; i++) samp(12'(i * 257));

        // R5: saturation in both directions
        cur_req = "R5";
        wr(0, 0, 16'h07FF); wr(0, 1, 16'hFFFF);
        wr(1, 0, 16'h0800); wr(1, 1, 16'hFFFF);
        wr(2, 2, 16'h7FFF); wr(3, 2, 16'h8000);
        commit_idle();
        for (int i = 0; i < 4; i++) samp(12'h000);
        for (int i = 0; i < 4; i++) begin
            samp(12'h7FF); samp(12'h800); samp(12'h7FF); samp(12'h800);
        end

        // R4: timing taps over merged history
        cur_req = "R4";
        for (int c = 0; c < 4; c++) begin
            wr(c, 0, 16'h0000); wr(c, 1, 16'h8000);
            wr(c, 2, 16'(16'h0100 * (c + 1)));
            wr(c, 3, 16'(-16'sh0800 * c));
            wr(c, 4, 16'h0400 + 16'(c));
        end
        commit_idle();
        for (int i = 0; i < 20; i++) samp(12'(i * 611));

        // R1 R6: gaps and sync mid-rotation
        cur_req = "R1";
        samp(12'h100);
        step(1'b0, 12'h0, 1'b0, 1'b0, 0, 0, 16'h0, 1'b0);
        samp(12'h200);
        step(1'b0, 12'h0, 1'b1, 1'b0, 0, 0, 16'h0, 1'b0);
        samp(12'h300); samp(12'h400);
        step(1'b1, 12'h500, 1'b1, 1'b0, 0, 0, 16'h0, 1'b0);
        for (int i = 0; i < 8; i++) samp(12'(i * 77));

        // random mix
        cur_req = "R1 R2 R4 R8";
        seed = $urandom(32'd31337);
        for (int i = 0; i < 3000; i++) begin
            bit v  = ($urandom % 4) != 0;
            bit s  = ($urandom % 64) == 0;
            bit w  = ($urandom % 8) == 0;
            bit cm = ($urandom % 32) == 0;
            int sel = $urandom % 8;
            logic [15:0] d = 16'($urandom);
            if (sel >= 2 && sel <= 4) d = 16'(sxw(longint'(d), 13));
            step(v, 12'($urandom), s, w, $urandom % 4, sel, d, cm);
        end
        for (int i = 0; i < 4; i++) step(1'b0, 12'h0, 1'b0, 1'b0, 0, 0, 16'h0, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule